// File: doc/BRIEF.md
# Serial Peripheral Master with Selectable Clock Schemes

This block is the master side of a four-wire synchronous serial link. Software-side logic pushes transmit words into a 16-entry transmit queue over a valid/ready stream. The sequencer pulls one word at a time, drives a serial clock, shifts the word out on the master-out line and captures the slave's reply on the master-in line. Each finished reply goes into a 16-entry receive queue, which is drained over a second valid/ready stream. The transfer length runs from 1 to 16 bits. The bit time is a programmed number of system clocks. A polarity bit and a delay bit select one of four clocking schemes.

The transmit stream has back-pressure: `tx_ready` is low while the transmit queue is full, and a word transfers on any cycle where `tx_valid` and `tx_ready` are both high. The receive stream presents data while `rx_valid` is high, and an entry leaves the queue on a cycle where `rx_ready` is also high. The serial side cannot be stalled. A reply that finds the receive queue full is discarded, and a sticky overrun flag is raised. The configuration inputs are sampled when a word starts, so changes take effect only on the next word.

Top module: `spi_master`

## Requirements
- R1: A word is `cfg_wlen`+1 bits long (0 encodes 1 bit, 15 encodes 16 bits), and the serial clock makes exactly 2*(`cfg_wlen`+1) edges while `ste_n` is low.
- R2: Bits leave on `simo` most significant first. A word shorter than 16 bits is taken from the upper bits of `tx_data`, starting at bit 15.
- R3: A received word is right-justified in `rx_data`: the first bit received lands at bit `cfg_wlen`, and all bits above it read 0.
- R4: With `ste_n` high the serial clock rests at `cfg_pol`. With `cfg_dly`=0 the master samples `somi` on the first edge of each bit (rest to active) and changes `simo` on the second edge. With `cfg_dly`=1 it changes `simo` on the first edge, half a bit ahead of the second, and samples on the second.
- R5: One bit lasts max(`cfg_brr`,3)+1 system clocks, so `cfg_brr` values 0 to 2 act as 3.
- R6: `ste_n` falls at least half a bit time before the first serial clock edge of a word and rises after its last edge.
- R7: While `cfg_txdis` is 1 when a word starts, `simo` stays 0 for that whole word, but the reply is still captured and queued.
- R8: The transmit queue holds 16 words. `tx_level` gives its fill, and `tx_ready` is low exactly when it is full.
- R9: The receive queue holds 16 words, with `rx_level` giving its fill. Its data stays put while `rx_ready` is low.
- R10: A reply finishing while the receive queue is full is dropped and sets `ovr`. `ovr` stays high until `ovr_clr` is pulsed.
- R11: After reset both queues are empty, `ovr` is 0, `ste_n` is 1 and `simo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit queue can accept a word |
| tx_data | input | 16 | Transmit word, left-aligned for short lengths |
| rx_valid | output | 1 | Receive queue holds a word |
| rx_ready | input | 1 | Consumer takes the head word |
| rx_data | output | 16 | Received word, right-justified |
| cfg_pol | input | 1 | Serial clock rest level |
| cfg_dly | input | 1 | Launch data half a bit early, sample on the second edge |
| cfg_txdis | input | 1 | Hold `simo` low (receive only) |
| cfg_wlen | input | 4 | Word length minus one |
| cfg_brr | input | 7 | Bit time minus one, in system clocks |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx_level | output | 5 | Transmit queue fill |
| rx_level | output | 5 | Receive queue fill |
| ovr | output | 1 | Sticky receive overrun |
| sck | output | 1 | Serial clock |
| simo | output | 1 | Master-out data |
| somi | input | 1 | Master-in data |
| ste_n | output | 1 | Slave transmit-enable, active low |

## Verification
- **Transmit pop:** a word accepted on the transmit stream is popped by an idle sequencer one clock later.
- **Receive push:** the reply enters the receive queue on the same clock edge on which `ste_n` rises, so the bench waits for `rx_valid` and then checks the data, the bits a slave model captured and the timing of every serial edge.
- **Edge timing:** the slave model stamps each edge of `sck` and `ste_n`. Bit time, lead time and edge count are therefore measured in nanoseconds against max(`cfg_brr`,3)+1 clocks of 8 ns, not sampled at one guessed cycle.
- **Sampling and drive:** queue levels and flags are sampled on falling clock edges, half a cycle after the rising edge that changes them, and stimulus is also applied on falling edges.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_H0,
    ST_H1,
    ST_TRAIL
  } spi_st_e;

  localparam int unsigned MIN_BRR = 3;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   wdata,
  input  logic                           pop,
  output logic [W-1:0]                   rdata,
  output logic                           full,
  output logic                           empty,
  output logic [$clog2(DEPTH+1)-1:0]     level
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_master_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned RW = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [DW-1:0]          tx_word,
  output logic                   pop,
  input  logic                   pol,
  input  logic                   dly,
  input  logic                   txdis,
  input  logic [$clog2(DW)-1:0]  wlen,
  input  logic [RW-1:0]          brr,
  input  logic                   somi,
  output logic                   sck,
  output logic                   simo,
  output logic                   ste_n,
  output logic                   done,
  output logic [DW-1:0]          rx_word
);
  localparam int unsigned LW = $clog2(DW);
  localparam int unsigned PW = RW + 1;

  spi_st_e       st;
  logic [PW-1:0] cnt, per_l, hl0, hl1, cur_half, per_new;
  logic [LW-1:0] bitn, wlen_l;
  logic [DW-1:0] shreg, rxsh;
  logic          pol_l, dly_l, txdis_l, last;
  logic [RW-1:0] brr_eff;

  assign brr_eff  = (brr < RW'(MIN_BRR)) ? RW'(MIN_BRR) : brr;
  assign per_new  = PW'(brr_eff) + PW'(1);
  assign hl0      = per_l >> 1;
  assign hl1      = per_l - hl0;
  assign cur_half = (st == ST_H0) ? hl0 : hl1;
  assign last     = (cnt == cur_half - PW'(1));
  assign pop      = (st == ST_IDLE) && start;
  assign done     = (st == ST_TRAIL) && last;
  assign rx_word  = rxsh;
  assign ste_n    = (st == ST_IDLE);
  assign simo     = (st != ST_IDLE) && !txdis_l && shreg[DW-1];

  always_comb begin
    case (st)
      ST_IDLE: sck = pol;
      ST_H0:   sck = pol_l ^ dly_l;
      ST_H1:   sck = pol_l ^ !dly_l;
      default: sck = pol_l;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      per_l   <= PW'(MIN_BRR + 1);
      bitn    <= '0;
      wlen_l  <= '0;
      shreg   <= '0;
      rxsh    <= '0;
      pol_l   <= 1'b0;
      dly_l   <= 1'b0;
      txdis_l <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          pol_l   <= pol;
          dly_l   <= dly;
          txdis_l <= txdis;
          wlen_l  <= wlen;
          per_l   <= per_new;
          shreg   <= tx_word;
          rxsh    <= '0;
          bitn    <= '0;
          cnt     <= '0;
          st      <= ST_LEAD;
        end
        ST_LEAD: begin
          cnt <= last ? '0 : cnt + PW'(1);
          if (last) st <= ST_H0;
        end
        ST_H0: begin
          cnt <= last ? '0 : cnt + PW'(1);
          if (last) begin
            rxsh <= {rxsh[DW-2:0], somi};
            st   <= ST_H1;
          end
        end
        ST_H1: begin
          cnt <= last ? '0 : cnt + PW'(1);
          if (last) begin
            if (bitn == wlen_l) begin
              st <= ST_TRAIL;
            end else begin
              shreg <= {shreg[DW-2:0], 1'b0};
              bitn  <= bitn + LW'(1);
              st    <= ST_H0;
            end
          end
        end
        ST_TRAIL: begin
          cnt <= last ? '0 : cnt + PW'(1);
          if (last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_master.sv
module spi_master #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned RW    = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tx_valid,
  output logic                          tx_ready,
  input  logic [DW-1:0]                 tx_data,
  output logic                          rx_valid,
  input  logic                          rx_ready,
  output logic [DW-1:0]                 rx_data,
  input  logic                          cfg_pol,
  input  logic                          cfg_dly,
  input  logic                          cfg_txdis,
  input  logic [$clog2(DW)-1:0]         cfg_wlen,
  input  logic [RW-1:0]                 cfg_brr,
  input  logic                          ovr_clr,
  output logic [$clog2(DEPTH+1)-1:0]    tx_level,
  output logic [$clog2(DEPTH+1)-1:0]    rx_level,
  output logic                          ovr,
  output logic                          sck,
  output logic                          simo,
  input  logic                          somi,
  output logic                          ste_n
);
  logic [DW-1:0] txq_head, rx_word;
  logic          txq_full, txq_empty, rxq_full, rxq_empty;
  logic          eng_pop, eng_done;

  assign tx_ready = !txq_full;
  assign rx_valid = !rxq_empty;

  spi_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_valid), .wdata(tx_data), .pop(eng_pop), .rdata(txq_head),
    .full(txq_full), .empty(txq_empty), .level(tx_level)
  );

  spi_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(eng_done), .wdata(rx_word), .pop(rx_ready), .rdata(rx_data),
    .full(rxq_full), .empty(rxq_empty), .level(rx_level)
  );

  spi_engine #(.DW(DW), .RW(RW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(!txq_empty), .tx_word(txq_head), .pop(eng_pop),
    .pol(cfg_pol), .dly(cfg_dly), .txdis(cfg_txdis),
    .wlen(cfg_wlen), .brr(cfg_brr), .somi(somi),
    .sck(sck), .simo(simo), .ste_n(ste_n),
    .done(eng_done), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ovr <= 1'b0;
    else if (eng_done && rxq_full) ovr <= 1'b1;
    else if (ovr_clr)              ovr <= 1'b0;
  end
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned RW    = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_pol,
  input logic                        sck,
  input logic                        simo,
  input logic                        ste_n,
  input logic                        ovr,
  input logic                        ovr_clr,
  input logic                        tx_ready,
  input logic                        rx_ready,
  input logic [$clog2(DEPTH+1)-1:0]  tx_level,
  input logic [$clog2(DEPTH+1)-1:0]  rx_level
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  assert_txq_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH));

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == CW'(DEPTH)) |-> !tx_ready);

  assert_rxq_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CW'(DEPTH));

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |=> rx_level >= $past(rx_level));

  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

  assert_idle_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ste_n && $past(ste_n) && $stable(cfg_pol)) |-> $stable(sck));

  assert_end_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ste_n) && $stable(cfg_pol)) |-> $stable(sck));

  assert_idle_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ste_n |-> !simo);
endmodule

bind spi_master spi_master_chk #(.DW(DW), .DEPTH(DEPTH), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .sck(sck), .simo(simo),
  .ste_n(ste_n), .ovr(ovr), .ovr_clr(ovr_clr), .tx_ready(tx_ready),
  .rx_ready(rx_ready), .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spi_master_tb.sv
`timescale 1ns/1ps
module spi_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0, rx_ready = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_ready, rx_valid;
  logic [15:0] rx_data;
  logic        cfg_pol = 1'b0, cfg_dly = 1'b0, cfg_txdis = 1'b0, ovr_clr = 1'b0;
  logic [3:0]  cfg_wlen = '0;
  logic [6:0]  cfg_brr = 7'd3;
  logic [4:0]  tx_level, rx_level;
  logic        ovr, sck, simo, ste_n;
  logic        somi = 1'b0;

  int checks = 0, errs = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .cfg_pol(cfg_pol), .cfg_dly(cfg_dly),
    .cfg_txdis(cfg_txdis), .cfg_wlen(cfg_wlen), .cfg_brr(cfg_brr),
    .ovr_clr(ovr_clr), .tx_level(tx_level), .rx_level(rx_level), .ovr(ovr),
    .sck(sck), .simo(simo), .somi(somi), .ste_n(ste_n)
  );

  // slave model
  logic [15:0] sl_word = '0;
  logic [15:0] cap;
  int          sl_len, lidx, edges;
  longint      t_fall, t_first, t_e2, t_last, t_rise;

  always @(negedge ste_n) begin
    t_fall = $time; edges = 0; cap = '0; lidx = 0;
    sl_len = int'(cfg_wlen) + 1;
    if (!cfg_dly) begin somi = sl_word[sl_len-1]; lidx = 1; end
  end
  always @(posedge ste_n) t_rise = $time;

  always @(sck) begin
    if (ste_n === 1'b0) begin
      if (edges == 0) t_first = $time;
      if (edges == 2) t_e2 = $time;
      t_last = $time;
      edges++;
      if ((sck !== cfg_pol) ^ cfg_dly) begin
        cap = {cap[14:0], simo};
      end else if (lidx < sl_len) begin
        somi = sl_word[sl_len-1-lidx];
        lidx++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic push_word(input logic [15:0] w);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = w;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(output bit got);
    got = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1; break; end
    end
  endtask

  task automatic pop_rx();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic reset_check(input string tag);
    chk(tx_level == 0, {tag, " R11 tx_level"}, tx_level, 0);
    chk(rx_level == 0 && !rx_valid, {tag, " R11 rx_level"}, rx_level, 0);
    chk(ovr == 0, {tag, " R11 ovr"}, ovr, 0);
    chk(ste_n == 1 && simo == 0, {tag, " R11 ste_n/simo"}, {ste_n, simo}, 2'b10);
    chk(sck == cfg_pol, {tag, " R4 idle sck"}, sck, cfg_pol);
  endtask

  // {pol, dly, wlen, brr, tx word, slave word}
  localparam int NV = 8;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd7,  7'd3,   16'hA500, 16'h773C},
    {1'b0, 1'b1, 4'd15, 7'd5,   16'h1234, 16'hBEEF},
    {1'b1, 1'b0, 4'd3,  7'd4,   16'hC000, 16'hFFF9},
    {1'b1, 1'b1, 4'd11, 7'd0,   16'hF0F0, 16'hFABC},
    {1'b0, 1'b0, 4'd0,  7'd9,   16'h8000, 16'hFFF1},
    {1'b1, 1'b1, 4'd4,  7'd127, 16'h5800, 16'hFFF3},
    {1'b0, 1'b1, 4'd15, 7'd10,  16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 4'd15, 7'd6,   16'h8001, 16'hFFFF}
  };

  initial begin
    #(8 * 190000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_check("reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      int len, per;
      logic [15:0] mask, exp_rx, exp_cap;
      bit got;
      e = VEC[v];
      cfg_pol = e[44]; cfg_dly = e[43]; cfg_wlen = e[42:39]; cfg_brr = e[38:32];
      sl_word = e[15:0];
      len  = int'(e[42:39]) + 1;
      per  = ((e[38:32] < 3) ? 3 : int'(e[38:32])) + 1;
      mask = (len == 16) ? 16'hFFFF : 16'((1 << len) - 1);
      exp_rx  = e[15:0] & mask;
      exp_cap = e[31:16] >> (16 - len);
      repeat (2) @(negedge clk);
      chk(sck == cfg_pol, "R4 rest level before word", sck, cfg_pol);
      push_word(e[31:16]);
      wait_rx(got);
      chk(got, "R9 reply queued", got, 1);
      chk(rx_data == exp_rx, "R3 right-justified reply", rx_data, exp_rx);
      chk(cap == exp_cap, "R2 msb-first upper bits on simo", cap, exp_cap);
      chk(edges == 2 * len, "R1 clock edge count", edges, 2 * len);
      chk((t_first - t_fall) >= per * 4, "R6 enable lead", t_first - t_fall, per * 4);
      chk(t_rise > t_last, "R6 enable held past last edge", t_rise, t_last);
      if (len >= 2)
        chk((t_e2 - t_first) == per * 8, "R5 bit time", t_e2 - t_first, per * 8);
      chk(sck == cfg_pol, "R4 rest level after word", sck, cfg_pol);
      pop_rx();
    end

    // R7: transmit disabled
    begin
      bit got;
      cfg_pol = 0; cfg_dly = 0; cfg_wlen = 4'd7; cfg_brr = 7'd3; cfg_txdis = 1;
      sl_word = 16'h005A;
      push_word(16'hFFFF);
      wait_rx(got);
      chk(cap == 0, "R7 simo held low", cap, 0);
      chk(rx_data == 16'h005A, "R7 reply still captured", rx_data, 16'h005A);
      pop_rx();
      cfg_txdis = 0;
    end

    // R10 / R9: receive overrun with 17 words
    begin
      cfg_wlen = 4'd3; cfg_brr = 7'd3; sl_word = 16'h0005;
      for (int i = 0; i < 17; i++) push_word(16'(i << 12));
      while (tx_level != 0) @(negedge clk);
      repeat (200) @(negedge clk);
      chk(rx_level == 16, "R9 receive queue full", rx_level, 16);
      chk(ovr == 1, "R10 overrun raised", ovr, 1);
      repeat (20) @(negedge clk);
      chk(ovr == 1, "R10 overrun sticky", ovr, 1);
      ovr_clr = 1; @(negedge clk); ovr_clr = 0;
      chk(ovr == 0, "R10 overrun cleared", ovr, 0);
      for (int i = 0; i < 16; i++) begin
        chk(rx_valid && rx_data == 16'h0005, "R9 drained word", rx_data, 16'h0005);
        pop_rx();
      end
      chk(!rx_valid && rx_level == 0, "R9 queue empty after drain", rx_level, 0);
    end

    // R8: transmit back-pressure
    begin
      int acc = 0;
      cfg_wlen = 4'd15; cfg_brr = 7'd127;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        tx_valid = tx_ready;
        tx_data  = 16'(i);
        if (tx_ready) acc++;
      end
      @(negedge clk);
      tx_valid = 0;
      chk(acc == 17, "R8 words accepted", acc, 17);
      chk(tx_level == 16 && !tx_ready, "R8 full stalls", tx_level, 16);
      rst_n = 0;
      repeat (2) @(negedge clk);
      reset_check("mid-run reset");
      rst_n = 1;
      repeat (2) @(negedge clk);
    end

    finish_run();
  end
endmodule